// File: doc/BRIEF.md
# Vector Beam Pattern Sequencer

This peripheral holds a short closed path of X/Y points and plays it back in a loop to steer a beam deflection stage. Software sets up the block through four word registers. Points are pushed one at a time into a per-axis sample port while a load flag is set. A speed word sets how many clock cycles each point of the path lasts. The control word then starts playback and sets the path length. It also chooses between two output styles: each point held flat for its step, or a straight-line ramp toward the following point.

The two outputs are signed 16-bit two's complement deflection values, one for each axis. They come with a strobe that marks the first cycle of every step. When playback is off, both axes sit at zero. The next start always begins at the first point.

Top module: `vbeam_seq`

## Requirements
- R1: After reset, both deflection outputs and the strobe are 0, and reading the control word and the speed word returns 0.
- R2: A read strobe loads `reg_rdata` on the next clock edge. For the control word it holds exactly the last 16-bit value written. For the speed word it holds the last speed written, zero-extended. For any other address it holds 0.
- R3: With the default base 0x20, the registers sit at these addresses: control at 0x20, speed at 0x21, X sample port at 0x22, Y sample port at 0x23. In the control word, bit 0 is run, bit 1 is load and bit 2 selects linear ramps. The path length is the field at bits [11:7]. A length of 0 behaves as 1, and a length above 16 behaves as 16.
- R4: While the load bit is set, each write to an axis sample port stores the value at that axis's next slot, starting from slot 0. Clearing the load bit sends both axes' slot pointers back to 0. A sample write made while the load bit is clear changes nothing.
- R5: While run is set, each point lasts L cycles, where L is the speed word, or 1 if the speed word is 0. The points are played in slot order and wrap to slot 0 after the last point. The first sample appears on the second clock edge after the control write. The strobe is 1 exactly in the first cycle of each step.
- R6: With linear ramps selected, cycle c (0 to L-1) of the step on point i outputs p[i] + trunc((p[i+1] - p[i]) * c / L), using signed arithmetic, where the following point wraps to slot 0. With ramps off, the output is p[i] for the whole step.
- R7: One cycle after run is cleared, both outputs and the strobe are 0. A later start begins again at point 0, cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| beam_x | output | 16 | Signed X deflection sample |
| beam_y | output | 16 | Signed Y deflection sample |
| sample_stb | output | 1 | High in the first cycle of each step |

## Verification
A slot pointer that drifts shows up in the very first replayed cycle as a wrong point, and it stays wrong for as long as the path plays. A step counter that miscounts moves the strobe and the point changes by at least one cycle within the first step. A wrong ramp term shows up on the second cycle of any ramped step. Each run is compared cycle by cycle for two full laps of the path, so any of these faults appears within one lap.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   localparam int OFS_CTRL  = 0;
   localparam int OFS_SPEED = 1;
   localparam int OFS_XS    = 2;
   localparam int OFS_YS    = 3;

   localparam int BIT_RUN   = 0;
   localparam int BIT_LOAD  = 1;
   localparam int BIT_LIN   = 2;
   localparam int SIZE_LSB  = 7;

   localparam int N_AXES    = 2;
endpackage

// File: rtl/vbs_regs.sv
module vbs_regs
   import vbs_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int SPEED_W = 16,
   parameter int BASE    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl,
   output logic [SPEED_W-1:0] speed,
   output logic              wr_x,
   output logic              wr_y
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(BASE + OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SPEED = ADDR_W'(BASE + OFS_SPEED);
   localparam logic [ADDR_W-1:0] A_XS    = ADDR_W'(BASE + OFS_XS);
   localparam logic [ADDR_W-1:0] A_YS    = ADDR_W'(BASE + OFS_YS);

   logic hit_ctrl, hit_speed;

   assign hit_ctrl  = addr == A_CTRL;
   assign hit_speed = addr == A_SPEED;
   assign wr_x      = wr && (addr == A_XS);
   assign wr_y      = wr && (addr == A_YS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         speed <= '0;
      end else if (wr) begin
         if (hit_ctrl)  ctrl  <= wdata;
         if (hit_speed) speed <= wdata[SPEED_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         if (hit_ctrl)       rdata <= ctrl;
         else if (hit_speed) rdata <= DATA_W'(speed);
         else                rdata <= '0;
      end
   end

   // R2: control word keeps exactly what was written
   p_ctrl_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctrl) |=> (ctrl == $past(wdata)));

   // R2: a read of the control word returns its current value
   p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_ctrl && !wr) |=> (rdata == ctrl));
endmodule

// File: rtl/vbs_pattern_ram.sv
module vbs_pattern_ram #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_a,
   input  logic [IDX_W-1:0]  rd_b,
   output logic [DATA_W-1:0] q_a,
   output logic [DATA_W-1:0] q_b
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  wptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
      end else if (!load_en) begin
         wptr <= '0;
      end else if (wr) begin
         wptr <= (wptr == IDX_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (load_en && wr) begin
         mem[wptr] <= wdata;
      end
   end

   assign q_a = mem[rd_a];
   assign q_b = mem[rd_b];

   // R4: clearing the load flag returns the slot pointer to 0
   p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> (wptr == '0));

   // R4: each accepted write moves to the next slot
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && wr && wptr != IDX_W'(DEPTH-1)) |=> (wptr == $past(wptr) + 1'b1));
endmodule

// File: rtl/vbs_stepper.sv
module vbs_stepper #(
   parameter int DEPTH   = 16,
   parameter int SPEED_W = 16,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SPEED_W-1:0] len,
   input  logic [IDX_W-1:0]   last,
   output logic [SPEED_W-1:0] cnt,
   output logic [IDX_W-1:0]   idx,
   output logic [IDX_W-1:0]   nxt
);
   logic step_end;

   assign step_end = (cnt >= len - 1'b1);
   assign nxt      = (idx >= last) ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         idx <= '0;
      end else if (!run) begin
         cnt <= '0;
         idx <= '0;
      end else if (step_end) begin
         cnt <= '0;
         idx <= nxt;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R7: stopping resets the step position
   p_stop_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0 && idx == '0));

   // R5: the last point of the path wraps to slot 0
   p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step_end && idx >= last) |=> (idx == '0));

   // R5: inside a step the cycle count only moves forward by one or restarts
   p_cnt_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step_end) |=> (cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

// File: rtl/vbs_ramp.sv
module vbs_ramp #(
   parameter int DATA_W    = 16,
   parameter int SPEED_W   = 16,
   parameter bit LINEAR_EN = 1'b1
) (
   input  logic               lin,
   input  logic [DATA_W-1:0]  cur,
   input  logic [DATA_W-1:0]  nxt,
   input  logic [SPEED_W-1:0] cnt,
   input  logic [SPEED_W-1:0] len,
   output logic [DATA_W-1:0]  val
);
   localparam int PW = DATA_W + SPEED_W + 2;

   generate
      if (LINEAR_EN) begin : g_lin
         logic signed [DATA_W:0] diff;
         logic signed [PW-1:0]   diff_e, cnt_e, len_e, prod, quot;

         assign diff   = $signed({nxt[DATA_W-1], nxt}) - $signed({cur[DATA_W-1], cur});
         assign diff_e = {{(PW-DATA_W-1){diff[DATA_W]}}, diff};
         assign cnt_e  = {{(PW-SPEED_W){1'b0}}, cnt};
         assign len_e  = {{(PW-SPEED_W){1'b0}}, len};
         assign prod   = diff_e * cnt_e;
         assign quot   = prod / len_e;
         assign val    = lin ? (cur + quot[DATA_W-1:0]) : cur;
      end else begin : g_hold
         logic unused_ok;
         assign unused_ok = ^{lin, nxt, cnt, len};
         assign val       = cur;
      end
   endgenerate
endmodule

// File: rtl/vbeam_seq.sv
module vbeam_seq
   import vbs_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int SPEED_W   = 16,
   parameter int DEPTH     = 16,
   parameter int BASE      = 32,
   parameter bit LINEAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] beam_x,
   output logic [DATA_W-1:0] beam_y,
   output logic              sample_stb
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int SIZE_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2)                   begin : g_chk_depth $error("DEPTH below 2"); end
      if (SIZE_LSB + SIZE_W > DATA_W)  begin : g_chk_size  $error("size field does not fit"); end
      if (SPEED_W > DATA_W)            begin : g_chk_speed $error("speed wider than data"); end
      if (BASE + OFS_YS >= 2**ADDR_W)  begin : g_chk_base  $error("register window off the map"); end
   endgenerate

   logic [DATA_W-1:0]  ctrl;
   logic [SPEED_W-1:0] speed, len, cnt;
   logic               wr_x, wr_y, run, load, lin;
   logic [SIZE_W-1:0]  sz;
   logic [IDX_W-1:0]   last, idx, nxt;
   logic [N_AXES-1:0][DATA_W-1:0] pt_cur, pt_nxt, val, out_q;
   logic               stb_q;

   vbs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPEED_W(SPEED_W), .BASE(BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata),
      .ctrl(ctrl), .speed(speed), .wr_x(wr_x), .wr_y(wr_y)
   );

   assign run  = ctrl[BIT_RUN];
   assign load = ctrl[BIT_LOAD];
   assign lin  = ctrl[BIT_LIN];
   assign sz   = ctrl[SIZE_LSB +: SIZE_W];
   assign last = (sz == '0) ? '0 :
                 (sz > SIZE_W'(DEPTH)) ? IDX_W'(DEPTH-1) : IDX_W'(sz - 1'b1);
   assign len  = (speed == '0) ? SPEED_W'(1) : speed;

   vbs_stepper #(.DEPTH(DEPTH), .SPEED_W(SPEED_W)) u_step (
      .clk(clk), .rst_n(rst_n), .run(run), .len(len), .last(last),
      .cnt(cnt), .idx(idx), .nxt(nxt)
   );

   generate
      for (genvar a = 0; a < N_AXES; a++) begin : g_axis
         vbs_pattern_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
            .clk(clk), .rst_n(rst_n), .load_en(load),
            .wr((a == 0) ? wr_x : wr_y), .wdata(reg_wdata),
            .rd_a(idx), .rd_b(nxt), .q_a(pt_cur[a]), .q_b(pt_nxt[a])
         );
         vbs_ramp #(.DATA_W(DATA_W), .SPEED_W(SPEED_W), .LINEAR_EN(LINEAR_EN)) u_ramp (
            .lin(lin), .cur(pt_cur[a]), .nxt(pt_nxt[a]),
            .cnt(cnt), .len(len), .val(val[a])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         stb_q <= 1'b0;
      end else if (!run) begin
         out_q <= '0;
         stb_q <= 1'b0;
      end else begin
         out_q <= val;
         stb_q <= (cnt == '0);
      end
   end

   assign beam_x     = out_q[0];
   assign beam_y     = out_q[1];
   assign sample_stb = stb_q;

   // R7: idle playback gives zero deflection and no strobe
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (beam_x == '0 && beam_y == '0 && !sample_stb));

   // R5: a strobe is never followed by another unless each step is one cycle long
   p_stb_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && run && $stable(speed) && speed > SPEED_W'(1)) |=> !sample_stb);

   // R6: with ramps off, the output holds between strobes
   p_hold_flat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !lin && !reg_wr && $past(run) && !$past(reg_wr) && sample_stb && cnt != '0)
      |=> (!sample_stb -> $stable(beam_x)));
endmodule

// File: tb/test_vbeam_seq.sv
`timescale 1ns/1ps
module test_vbeam_seq;
   localparam logic [7:0] A_CTRL = 8'h20, A_SPEED = 8'h21, A_XS = 8'h22, A_YS = 8'h23;
   localparam int NSCN = 7;
   localparam int SCN_SIZE  [NSCN] = '{4, 4, 1, 0, 20, 5, 3};
   localparam int SCN_SPEED [NSCN] = '{2, 3, 2, 1, 1, 0, 5};
   localparam int SCN_LIN   [NSCN] = '{0, 1, 0, 0, 0, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_rdata, beam_x, beam_y;
   logic        sample_stb;
   int          nvec = 0, nerr = 0;
   bit          done = 1'b0;
   logic [15:0] xs [16];
   logic [15:0] ys [16];

   always #4 clk = ~clk;

   vbeam_seq i_vbeam_seq (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .beam_x(beam_x), .beam_y(beam_y), .sample_stb(sample_stb)
   );

   function automatic logic [15:0] px(int i);
      return 16'(i * 13107 - 20000);
   endfunction
   function automatic logic [15:0] py(int i);
      return (i == 0) ? 16'hC000 : 16'(30000 - i * 9000);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [15:0] model(logic [15:0] pc, logic [15:0] pn, int c, int l, bit ln);
      int cur, d;
      cur = int'($signed(pc));
      d   = int'($signed(pn)) - cur;
      return ln ? 16'(cur + (d * c) / l) : pc;
   endfunction

   task automatic play(int sz, int sp, bit ln, int ncyc, string tag);
      int eff, l;
      logic [15:0] cw, rb;
      eff = (sz == 0) ? 1 : ((sz > 16) ? 16 : sz);
      l   = (sp == 0) ? 1 : sp;
      cw  = 16'(1 | (int'(ln) << 2) | (sz << 7));
      wr(A_SPEED, 16'(sp));
      wr(A_CTRL, cw);
      for (int k = 0; k < ncyc; k++) begin
         int s, c, i, n;
         @(negedge clk);
         s = k / l; c = k % l; i = s % eff; n = (i + 1) % eff;
         chk({tag, " x"}, {16'h0, beam_x}, {16'h0, model(xs[i], xs[n], c, l, ln)});
         chk({tag, " y"}, {16'h0, beam_y}, {16'h0, model(ys[i], ys[n], c, l, ln)});
         chk({tag, " stb"}, {31'h0, sample_stb}, {31'h0, c == 0});
      end
      rd(A_CTRL, rb);
      chk("R2 ctrl readback", {16'h0, rb}, {16'h0, cw});
      rd(A_SPEED, rb);
      chk("R2 speed readback", {16'h0, rb}, 32'(sp));
      wr(A_CTRL, 16'h0000);
      @(negedge clk);
      chk("R7 stop x", {16'h0, beam_x}, 32'h0);
      chk("R7 stop y", {16'h0, beam_y}, 32'h0);
      chk("R7 stop stb", {31'h0, sample_stb}, 32'h0);
   endtask

   initial begin
      logic [15:0] rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset x", {16'h0, beam_x}, 32'h0);
      chk("R1 reset y", {16'h0, beam_y}, 32'h0);
      chk("R1 reset stb", {31'h0, sample_stb}, 32'h0);
      rd(A_CTRL, rb);
      chk("R1 reset ctrl", {16'h0, rb}, 32'h0);
      rd(A_SPEED, rb);
      chk("R1 reset speed", {16'h0, rb}, 32'h0);
      rd(A_XS, rb);
      chk("R2 sample port reads 0", {16'h0, rb}, 32'h0);

      // R3 R4: load full pattern through the axis ports
      for (int i = 0; i < 16; i++) begin xs[i] = px(i); ys[i] = py(i); end
      wr(A_CTRL, 16'h0002);
      for (int i = 0; i < 16; i++) begin
         wr(A_XS, xs[i]);
         wr(A_YS, ys[i]);
      end
      wr(A_CTRL, 16'h0000);

      // vector table: R5 hold playback, R6 ramps, R3 size 0 and clamp
      for (int v = 0; v < NSCN; v++) begin
         int eff, l;
         eff = (SCN_SIZE[v] == 0) ? 1 : ((SCN_SIZE[v] > 16) ? 16 : SCN_SIZE[v]);
         l   = (SCN_SPEED[v] == 0) ? 1 : SCN_SPEED[v];
         play(SCN_SIZE[v], SCN_SPEED[v], SCN_LIN[v][0], 2 * eff * l + 2,
              SCN_LIN[v] != 0 ? "R6 ramp" : "R5 R3 hold");
      end

      // R4: pointer restart after load clear, and writes ignored with load clear
      wr(A_CTRL, 16'h0002);
      wr(A_XS, 16'h1111); wr(A_XS, 16'h2222); wr(A_XS, 16'h3333);
      wr(A_CTRL, 16'h0000);
      wr(A_CTRL, 16'h0002);
      wr(A_XS, 16'h4444); wr(A_XS, 16'h5555);
      wr(A_CTRL, 16'h0000);
      wr(A_XS, 16'h7777);
      xs[0] = 16'h4444; xs[1] = 16'h5555; xs[2] = 16'h3333;
      play(3, 1, 1'b0, 6, "R4 reload");

      // R2: arbitrary control value read back exactly
      wr(A_CTRL, 16'hF8F8);
      rd(A_CTRL, rb);
      chk("R2 exact ctrl", {16'h0, rb}, 32'h0000F8F8);
      wr(A_CTRL, 16'h0000);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nvec++; nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule